// File: doc/BRIEF.md
# I2C Register Target with Per-Byte CRC

This block is an I2C target that gives a bus controller read and write access to a small bank of 8-bit registers. SCL and SDA are brought into a fast system clock domain through synchronizer flops. The block finds START, repeated START and STOP conditions in the sampled lines and then runs the byte protocol as a state machine clocked by the system clock. SDA is open-drain: the block only ever asks for the line to be pulled low, through `sda_oe_o`.

A transfer begins with the device address byte. After that, a write sends a register index followed by data bytes. A read either turns the bus around with a repeated START, or ends the index phase with STOP and opens a new read transfer. The register pointer advances by one after every data byte, so block transfers walk through the bank. The pointer wraps at the end of the bank.

An optional CRC-8 can guard every data byte. When it is on, each written data byte is followed by a CRC byte that the target checks. Each read data byte is followed by a CRC byte that the target sends. A separate configuration-update input controls when a new CRC-enable setting takes effect. An inactivity timer drops the bus logic back to idle if SCL is held low for too long.

Top module: `i2ct_top`

## Requirements
- R1: After reset the target does not drive SDA and every register reads as 0x00.
- R2: The target acknowledges an address byte only when bits 7:1 equal `dev_addr_i`. Bit 0 selects a read (1) or a write (0). With `dev_addr_i` = 0x08, the address bytes are 0x10 for a write and 0x11 for a read. Any other address gets no acknowledge.
- R3: In a write, the byte after the address sets the register pointer to its low log2(DEPTH) bits. Each committed data byte is stored at the pointer, and the pointer then advances by one, modulo DEPTH.
- R4: A read returns the register at the pointer and then advances the pointer by one per data byte. This holds both for a read that follows a repeated START and for one that follows STOP and a new START. The controller ACKs (SDA low) each data byte it wants to continue past.
- R5: With CRC active, every written data byte is followed by a CRC byte. The CRC is CRC-8 with polynomial 0x07, initial value 0, MSB first, with no reflection and no final XOR. For the first data byte it covers the write-address byte, the register byte and the data byte. For each later data byte it covers only that byte. A matching CRC is acknowledged and the data byte is committed.
- R6: A CRC byte that does not match is not acknowledged and its data byte is not committed. The target then ignores further bytes until the next START.
- R7: With CRC active, a read that uses a repeated START sends a CRC byte after each data byte. The first one covers the write-address byte, the register byte, the read-address byte and the data byte. Each later one covers only its own data byte.
- R8: With CRC active, a read that follows STOP and a new START has a first CRC that covers only the read-address byte and the data byte.
- R9: When the controller does not acknowledge (SDA high) a data or CRC byte sent by the target, the target stops driving SDA for the rest of the transfer.
- R10: A change on `crc_en_i` takes effect only when `cfg_mode_i` falls. CRC is off after reset.
- R11: When `to_en_i` is 1 and SCL stays low for `to_limit_i` system clocks, the target returns to idle and releases SDA. When `to_en_i` is 0, a held-low SCL does not disturb the transfer.
- R12: A STOP always returns the target to idle with SDA released, and the target only starts driving SDA while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_addr_i | input | 7 | Device address the target answers to |
| cfg_mode_i | input | 1 | Configuration-update mode; its falling edge loads the CRC setting |
| crc_en_i | input | 1 | Requested CRC enable |
| to_en_i | input | 1 | Enables the SCL-low timeout |
| to_limit_i | input | TOW | Timeout length in system clocks |

## Verification
The assertions assume that SCL holds each level for at least several system clocks, so that a synchronized edge is seen before the line moves again. They also assume that the controller changes SDA only while SCL is low, except to signal START and STOP. The stimulus meets these assumptions by bit-banging the bus with at least ten system clocks per SCL half period. It sets SDA one quarter period after every falling SCL edge, and it samples the wired-AND bus line in the middle of each high phase. Random register indexes, lengths and data drive both CRC modes and both read forms. Directed sequences force a corrupted CRC, a NACK by the controller, pointer wrap, an address change and a held-low SCL.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    // Protocol states of the target
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_WCRC,
        ST_WCRC_ACK,
        ST_RDAT,
        ST_RDAT_MACK,
        ST_RCRC,
        ST_RCRC_MACK
    } st_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic              sclp_d, sclp_q, sdap_d, sdap_q;

    always_comb begin
        scl_d  = {scl_q[STAGES-2:0], scl_i};
        sda_d  = {sda_q[STAGES-2:0], sda_i};
        sclp_d = scl_q[STAGES-1];
        sdap_d = sda_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= '1;
            sda_q  <= '1;
            sclp_q <= 1'b1;
            sdap_q <= 1'b1;
        end else begin
            scl_q  <= scl_d;
            sda_q  <= sda_d;
            sclp_q <= sclp_d;
            sdap_q <= sdap_d;
        end
    end

    assign scl_o      = scl_q[STAGES-1];
    assign sda_o      = sda_q[STAGES-1];
    assign scl_rise_o = scl_o & ~sclp_q;
    assign scl_fall_o = ~scl_o & sclp_q;
    assign start_o    = scl_o & sclp_q & sdap_q & ~sda_o;
    assign stop_o     = scl_o & sclp_q & ~sdap_q & sda_o;

endmodule

// File: rtl/i2ct_crc8.sv
module i2ct_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);
    logic [7:0] acc;

    always_comb begin
        acc = crc_i ^ data_i;
        for (int i = 0; i < 8; i++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/i2ct_regbank.sv
module i2ct_regbank #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/i2ct_top.sv
module i2ct_top
    import i2ct_pkg::*;
#(
    parameter int         DEPTH       = 8,
    parameter int         TOW         = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic       CRC_RESET   = 1'b0,
    parameter logic [7:0] CRC_POLY    = 8'h07
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           sda_oe_o,
    input  logic [6:0]     dev_addr_i,
    input  logic           cfg_mode_i,
    input  logic           crc_en_i,
    input  logic           to_en_i,
    input  logic [TOW-1:0] to_limit_i
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        st_e           st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [7:0]    crc;
        logic [7:0]    wbuf;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          rw;
        logic          mack;
        logic          upd;
        logic          crc_on;
        logic [TOW-1:0] to_cnt;
    } state_t;

    state_t r_q, r_d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] crc_rx, crc_tx, rd_data, wdat;
    logic [AW-1:0] waddr;
    logic we, to_hit, load_tx;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    i2ct_crc8 #(.POLY(CRC_POLY)) u_crc_rx (
        .crc_i (r_q.crc),
        .data_i(r_q.sh),
        .crc_o (crc_rx)
    );

    i2ct_crc8 #(.POLY(CRC_POLY)) u_crc_tx (
        .crc_i (r_q.crc),
        .data_i(rd_data),
        .crc_o (crc_tx)
    );

    i2ct_regbank #(.DEPTH(DEPTH), .DW(8)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .waddr_i(waddr),
        .wdata_i(wdat),
        .raddr_i(r_q.ptr),
        .rdata_o(rd_data)
    );

    always_comb begin
        r_d     = r_q;
        we      = 1'b0;
        waddr   = r_q.ptr;
        wdat    = r_q.sh;
        load_tx = 1'b0;

        // configuration: new CRC setting loads on exit from update mode
        r_d.upd = cfg_mode_i;
        if (r_q.upd && !cfg_mode_i) r_d.crc_on = crc_en_i;

        // SCL-low inactivity timer
        to_hit = to_en_i && !scl_s && (r_q.to_cnt == to_limit_i);
        if (!to_en_i || scl_s) begin
            r_d.to_cnt = '0;
        end else if (r_q.to_cnt != to_limit_i) begin
            r_d.to_cnt = r_q.to_cnt + 1'b1;
        end

        if (to_hit || stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.crc = '0;
            r_d.cnt = '0;
        end else if (start_det) begin
            r_d.st  = ST_ADDR;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;

                ST_ADDR, ST_REG, ST_WDAT, ST_WCRC: begin
                    if (scl_rise && r_q.cnt != 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = '0;
                        r_d.oe  = 1'b1;
                        unique case (r_q.st)
                            ST_ADDR: begin
                                if (r_q.sh[7:1] == dev_addr_i) begin
                                    r_d.rw  = r_q.sh[0];
                                    r_d.crc = crc_rx;
                                    r_d.st  = ST_ADDR_ACK;
                                end else begin
                                    r_d.oe  = 1'b0;
                                    r_d.crc = '0;
                                    r_d.st  = ST_IDLE;
                                end
                            end
                            ST_REG: begin
                                r_d.ptr = r_q.sh[AW-1:0];
                                r_d.crc = crc_rx;
                                r_d.st  = ST_REG_ACK;
                            end
                            ST_WDAT: begin
                                r_d.st = ST_WDAT_ACK;
                                if (r_q.crc_on) begin
                                    r_d.wbuf = r_q.sh;
                                    r_d.crc  = crc_rx;
                                end else begin
                                    we      = 1'b1;
                                    wdat    = r_q.sh;
                                    r_d.ptr = r_q.ptr + 1'b1;
                                    r_d.crc = '0;
                                end
                            end
                            default: begin
                                r_d.crc = '0;
                                if (r_q.sh == r_q.crc) begin
                                    we      = 1'b1;
                                    wdat    = r_q.wbuf;
                                    r_d.ptr = r_q.ptr + 1'b1;
                                    r_d.st  = ST_WCRC_ACK;
                                end else begin
                                    r_d.oe = 1'b0;
                                    r_d.st = ST_IDLE;
                                end
                            end
                        endcase
                    end
                end

                ST_ADDR_ACK, ST_REG_ACK, ST_WDAT_ACK, ST_WCRC_ACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        unique case (r_q.st)
                            ST_ADDR_ACK: begin
                                if (r_q.rw) load_tx = 1'b1;
                                else        r_d.st  = ST_REG;
                            end
                            ST_REG_ACK:  r_d.st = ST_WDAT;
                            ST_WDAT_ACK: r_d.st = r_q.crc_on ? ST_WCRC : ST_WDAT;
                            default:     r_d.st = ST_WDAT;
                        endcase
                    end
                end

                ST_RDAT, ST_RCRC: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = (r_q.st == ST_RDAT) ? ST_RDAT_MACK : ST_RCRC_MACK;
                        end else begin
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.oe  = ~r_q.sh[6];
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end

                ST_RDAT_MACK, ST_RCRC_MACK: begin
                    if (scl_rise) begin
                        r_d.mack = sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st  = ST_IDLE;
                            r_d.oe  = 1'b0;
                            r_d.crc = '0;
                        end else if (r_q.st == ST_RDAT_MACK && r_q.crc_on) begin
                            r_d.sh  = r_q.crc;
                            r_d.oe  = ~r_q.crc[7];
                            r_d.crc = '0;
                            r_d.cnt = '0;
                            r_d.st  = ST_RCRC;
                        end else begin
                            load_tx = 1'b1;
                        end
                    end
                end

                default: begin
                    r_d.st = ST_IDLE;
                    r_d.oe = 1'b0;
                end
            endcase
        end

        // fetch the next read byte, fold it into the CRC, advance pointer
        if (load_tx) begin
            r_d.sh  = rd_data;
            r_d.crc = crc_tx;
            r_d.ptr = r_q.ptr + 1'b1;
            r_d.oe  = ~rd_data[7];
            r_d.cnt = '0;
            r_d.st  = ST_RDAT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.crc_on <= CRC_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;

    // R12: STOP always leaves SDA released
    a_r12_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !r_q.oe);

    // R12: the target only begins to pull SDA while SCL is low
    a_r12_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.oe) |-> !scl_s);

    // R11: an expired timer frees SDA and idles the state machine
    a_r11_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> (!r_q.oe && r_q.st == ST_IDLE));

    // R10: the CRC setting holds unless update mode is being left
    a_r10_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.upd && !cfg_mode_i) |=> $stable(r_q.crc_on));

    // R3: each committed byte moves the pointer on by one
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (r_q.ptr == AW'($past(r_q.ptr) + 1'b1)));

endmodule

// File: tb/tb_i2ct_top.sv
module tb_i2ct_top;
    localparam int DEPTH = 8;
    localparam int Q     = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [6:0]  dev_addr = 7'h08;
    logic        cfg_mode = 1'b0;
    logic        crc_en = 1'b0;
    logic        to_en = 1'b1;
    logic [15:0] to_limit = 16'd300;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] mdl   [DEPTH];
    logic [7:0] wdata [16];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2ct_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .dev_addr_i(dev_addr),
        .cfg_mode_i(cfg_mode),
        .crc_en_i  (crc_en),
        .to_en_i   (to_en),
        .to_limit_i(to_limit)
    );

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] v;
        logic fb;
        v = c;
        for (int i = 7; i >= 0; i--) begin
            fb = v[7] ^ d[i];
            v  = {v[6:0], 1'b0};
            if (fb) v = v ^ 8'h07;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic tx_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        tx_bits(b);
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = ~sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic rx_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(); wq(); scl = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq(); scl = 1'b0;
        end
        wq(); sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] r, input int n,
                            input bit use_crc, input int bad_at, input string tag);
        logic [7:0] c;
        bit ack;
        bus_start();
        tx_byte({a, 1'b0}, ack); chk(tag, "wr addr ack", ack, 1);
        c = crc8(8'h00, {a, 1'b0});
        tx_byte(r, ack); chk(tag, "reg ack", ack, 1);
        c = crc8(c, r);
        for (int i = 0; i < n; i++) begin
            c = crc8(c, wdata[i]);
            tx_byte(wdata[i], ack); chk(tag, "data ack", ack, 1);
            if (use_crc) begin
                if (i == bad_at) begin
                    tx_byte(c ^ 8'h5A, ack); chk(tag, "bad crc nack", ack, 0);
                    tx_byte(8'hC3, ack);     chk(tag, "ignored after bad crc", ack, 0);
                    break;
                end
                tx_byte(c, ack); chk(tag, "crc ack", ack, 1);
                c = 8'h00;
            end
            mdl[(int'(r) + i) % DEPTH] = wdata[i];
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] r, input int n,
                           input bit use_crc, input bit rstart, input bit extra,
                           input string tag);
        logic [7:0] c, d, e;
        bit ack, last;
        bus_start();
        tx_byte({a, 1'b0}, ack); chk(tag, "wr addr ack", ack, 1);
        tx_byte(r, ack);         chk(tag, "reg ack", ack, 1);
        if (rstart) begin
            c = crc8(crc8(8'h00, {a, 1'b0}), r);
            bus_start();
        end else begin
            bus_stop();
            bus_start();
            c = 8'h00;
        end
        tx_byte({a, 1'b1}, ack); chk(tag, "rd addr ack", ack, 1);
        c = crc8(c, {a, 1'b1});
        for (int i = 0; i < n; i++) begin
            last = (i == n - 1);
            e = mdl[(int'(r) + i) % DEPTH];
            rx_byte(last && !use_crc, d); chk(tag, "read data", d, e);
            c = crc8(c, e);
            if (use_crc) begin
                rx_byte(last, d); chk(tag, "read crc", d, c);
                c = 8'h00;
            end
        end
        if (extra) begin
            rx_byte(1'b1, d); chk(tag, "sda released after nack", d, 8'hFF);
        end
        bus_stop();
    endtask

    task automatic set_crc(input bit en);
        cfg_mode = 1'b1; crc_en = en;
        repeat (4) @(negedge clk);
        cfg_mode = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] r;
        int n;
        void'($urandom(32'h1C2D3E4F));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1", "sda_oe after reset", sda_oe, 0);
        do_read(7'h08, 8'h00, DEPTH, 1'b0, 1'b1, 1'b0, "R1");

        // R3 / R4: block write and both read forms, no CRC
        wdata[0] = 8'hA5; wdata[1] = 8'h3C; wdata[2] = 8'h81; wdata[3] = 8'h7E;
        do_write(7'h08, 8'h02, 4, 1'b0, -1, "R3");
        do_read(7'h08, 8'h02, 4, 1'b0, 1'b1, 1'b0, "R4");
        do_read(7'h08, 8'h03, 3, 1'b0, 1'b0, 1'b0, "R4");

        // R3: pointer wrap past the last register
        wdata[0] = 8'h11; wdata[1] = 8'h22; wdata[2] = 8'h33;
        do_write(7'h08, 8'h07, 3, 1'b0, -1, "R3");
        do_read(7'h08, 8'h00, DEPTH, 1'b0, 1'b1, 1'b0, "R3");

        // R2: foreign address ignored, then a new configured address
        bus_start();
        tx_byte({7'h09, 1'b0}, ack); chk("R2", "foreign addr nack", ack, 0);
        bus_stop();
        dev_addr = 7'h2A;
        wdata[0] = 8'hC7;
        do_write(7'h2A, 8'h05, 1, 1'b0, -1, "R2");
        do_read(7'h2A, 8'h05, 1, 1'b0, 1'b0, 1'b0, "R2");
        bus_start();
        tx_byte({7'h08, 1'b1}, ack); chk("R2", "old addr nack", ack, 0);
        bus_stop();
        dev_addr = 7'h08;

        // R10: request CRC but stay in update mode -> still plain writes
        cfg_mode = 1'b1; crc_en = 1'b1;
        wdata[0] = 8'h5B; wdata[1] = 8'hE4;
        do_write(7'h08, 8'h01, 2, 1'b0, -1, "R10");
        do_read(7'h08, 8'h01, 2, 1'b0, 1'b1, 1'b0, "R10");
        cfg_mode = 1'b0;
        repeat (4) @(negedge clk);

        // R5: CRC single and block write; R7 / R8: CRC reads
        wdata[0] = 8'h9D;
        do_write(7'h08, 8'h04, 1, 1'b1, -1, "R5");
        wdata[0] = 8'h01; wdata[1] = 8'hFE; wdata[2] = 8'h6A;
        do_write(7'h08, 8'h05, 3, 1'b1, -1, "R5");
        do_read(7'h08, 8'h04, 4, 1'b1, 1'b1, 1'b0, "R7");
        do_read(7'h08, 8'h03, 3, 1'b1, 1'b0, 1'b0, "R8");

        // R6: corrupt the second CRC of a three-byte write
        wdata[0] = 8'h44; wdata[1] = 8'h55; wdata[2] = 8'h66;
        do_write(7'h08, 8'h00, 3, 1'b1, 1, "R6");
        do_read(7'h08, 8'h00, 3, 1'b1, 1'b1, 1'b0, "R6");

        // R9: NACK of a CRC byte releases the bus
        do_read(7'h08, 8'h02, 2, 1'b1, 1'b1, 1'b1, "R9");

        // random traffic with CRC active
        for (int k = 0; k < 8; k++) begin
            r = 8'($urandom_range(0, 255));
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) wdata[i] = 8'($urandom);
            do_write(7'h08, r, n, 1'b1, -1, "R5");
            do_read(7'h08, r, n, 1'b1, 1'($urandom_range(0, 1)), 1'b0, "R7");
        end

        // R10: leave update mode with CRC off
        set_crc(1'b0);
        do_read(7'h08, 8'h06, 2, 1'b0, 1'b1, 1'b1, "R9");

        for (int k = 0; k < 8; k++) begin
            r = 8'($urandom_range(0, 255));
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) wdata[i] = 8'($urandom);
            do_write(7'h08, r, n, 1'b0, -1, "R3");
            do_read(7'h08, r, n, 1'b0, 1'($urandom_range(0, 1)), 1'b0, "R4");
        end

        // R11: SCL held low during the address ACK
        to_limit = 16'd150;
        bus_start();
        tx_bits({7'h08, 1'b0});
        sda_m = 1'b1;
        wq();
        chk("R11", "ack driven before timeout", sda_oe, 1);
        repeat (200) @(negedge clk);
        chk("R11", "sda released by timeout", sda_oe, 0);
        scl = 1'b1; wq();
        bus_stop();
        to_en = 1'b0;
        bus_start();
        tx_bits({7'h08, 1'b0});
        sda_m = 1'b1;
        repeat (400) @(negedge clk);
        chk("R11", "ack kept with timer off", sda_oe, 1);
        scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        bus_stop();
        chk("R12", "released after stop", sda_oe, 0);
        to_en = 1'b1;
        to_limit = 16'd300;
        do_read(7'h08, 8'h00, 2, 1'b0, 1'b0, 1'b0, "R12");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule